// File: doc/BRIEF.md
# Asynchronous ROM Read Controller

This block sits on the host side of a shared bus that carries several 16-bit asynchronous read-only memories. A requester hands it a word address. The upper address bits pick one device, and the lower bits go out on the shared address lines. The controller pulls that device's active-low chip enable and keeps every other device in standby with its chip enable high. It then drives one active-low output-enable line that all devices share. It counts clock cycles so that the data is sampled only after the slowest of the access paths has elapsed. At that point it latches the word, returns it with a one-cycle valid pulse, and releases the bus.

The devices only guarantee zero output hold after an address change, so the address stays fixed until the data has been captured. The outputs of the previous device can keep driving the bus for a float time after release. For that reason, a request aimed at a different device is held back until that time has passed. A request to the same device proceeds without delay. Every timing value is a parameter given in clock cycles, derived from the memory's nanosecond figures and the clock period.

Top module: `romReadCtrl`

## Requirements
- R1: While reset is low, every chip enable and the output enable are high (deasserted), reqReady is 1 and rspValid is 0.
- R2: A request is taken on a clock edge where reqValid and reqReady are both 1. reqReady is 0 from the next cycle until the cycle in which rspValid is high, and is 1 again in that cycle.
- R3: The top log2(NUM_DEV) address bits select device n, whose busCeN bit n is driven low (0 = selected). busAddr carries the low DEV_ADDR_W address bits and holds them unchanged while a chip enable is low.
- R4: busOeN falls ACC_CYC-OE_CYC cycles after the chip enable falls. It is never low while all chip enables are high.
- R5: busData is latched on the edge ACC_CYC cycles after the chip enable fell. rspValid is 1 for exactly the following cycle. rspData shows the latched word from that cycle until the next capture.
- R6: The selected chip enable and the output enable both rise on the capture edge.
- R7: A request taken while idle for the same device as the last completed read drives its chip enable low in the cycle right after acceptance.
- R8: For a different device, the chip enable does not fall before FLOAT_CYC+1 edges after the edge that released the bus. If the request arrives later than that, the chip enable falls right after acceptance. After reset, device 0 counts as the last device.
- R9: At most one chip enable is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | DEV_ADDR_W+log2(NUM_DEV) | Word address; top bits select the device |
| reqReady | output | 1 | Controller can take a request |
| rspValid | output | 1 | One-cycle pulse: rspData holds a new word |
| rspData | output | DATA_W | Last captured word |
| busAddr | output | DEV_ADDR_W | Shared address lines |
| busCeN | output | NUM_DEV | Per-device chip enables, active low |
| busOeN | output | 1 | Shared output enable, active low |
| busData | input | DATA_W | Shared data lines from the memories |

## Verification
The bench drives a chain of reads that alternates between back-to-back hits on one device, immediate switches to another device, and switches made after one, two and five idle cycles. The same-device runs show that no float gap is inserted. The immediate switches show that the gap is enforced. The delayed switches show that the gap is only as long as the float time still remaining. The bench's memory model returns a poison word unless the chip enable and the output enable have each been low for their full access counts, so a capture taken even one cycle early shows up as a data mismatch. Address extremes and all four devices are covered, so decode errors and address bit slips also show up.

// File: rtl/romRdPkg.sv
package romRdPkg;
  typedef struct packed {
    logic load;
    logic ceOn;
    logic oeOn;
    logic capture;
  } rdStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GAP    = 2'd1,
    ST_ACCESS = 2'd2
  } rdState_t;
endpackage

// File: rtl/romRdCtrl.sv
module romRdCtrl
  import romRdPkg::*;
#(
  parameter int ACC_CYC   = 6,
  parameter int OE_CYC    = 3,
  parameter int FLOAT_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       sameDev,
  output logic       reqReady,
  output rdStrobe_t  strobe
);
  localparam int  CW         = $clog2(ACC_CYC + 1);
  localparam int  GW         = $clog2(FLOAT_CYC + 2);
  localparam int  OE_LEAD    = ACC_CYC - OE_CYC;
  localparam bit  OE_AT_START = (OE_LEAD == 0);

  rdState_t        state, nextState;
  logic [CW-1:0]   cnt;
  logic [GW-1:0]   gapCnt;
  logic            gapFull;

  assign gapFull = (gapCnt >= GW'(FLOAT_CYC));

  always_comb begin
    strobe    = '0;
    nextState = state;
    reqReady  = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          if (sameDev || gapFull) begin
            strobe.ceOn = 1'b1;
            strobe.oeOn = OE_AT_START;
            nextState   = ST_ACCESS;
          end else begin
            nextState = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gapFull) begin
          strobe.ceOn = 1'b1;
          strobe.oeOn = OE_AT_START;
          nextState   = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (OE_LEAD > 0 && cnt == CW'(OE_LEAD - 1)) strobe.oeOn = 1'b1;
        if (cnt == CW'(ACC_CYC - 1)) begin
          strobe.capture = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      gapCnt <= GW'(FLOAT_CYC);
    end else begin
      state <= nextState;
      if (strobe.ceOn)             cnt <= '0;
      else if (state == ST_ACCESS) cnt <= cnt + 1'b1;
      if (strobe.capture)          gapCnt <= '0;
      else if (!gapFull)           gapCnt <= gapCnt + 1'b1;
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R7
  same_dev_no_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && sameDev) |=> (state == ST_ACCESS));
endmodule

// File: rtl/romRdDatapath.sv
module romRdDatapath
  import romRdPkg::*;
#(
  parameter int NUM_DEV    = 4,
  parameter int DEV_ADDR_W = 16,
  parameter int DATA_W     = 16,
  parameter int SEL_W      = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rdStrobe_t                     strobe,
  input  logic [DEV_ADDR_W+SEL_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]             busData,
  output logic                          sameDev,
  output logic [DEV_ADDR_W-1:0]         busAddr,
  output logic [NUM_DEV-1:0]            busCeN,
  output logic                          busOeN,
  output logic                          rspValid,
  output logic [DATA_W-1:0]             rspData
);
  localparam int ADDR_W = DEV_ADDR_W + SEL_W;

  logic [DEV_ADDR_W-1:0] addrQ;
  logic [SEL_W-1:0]      devQ, lastDevQ, newDev;
  logic                  ceActive, oeQ;

  assign newDev  = reqAddr[ADDR_W-1 -: SEL_W];
  assign sameDev = (newDev == lastDevQ);
  assign busAddr = addrQ;
  assign busOeN  = !oeQ;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_ce
    assign busCeN[d] = !(ceActive && devQ == SEL_W'(d));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      devQ     <= '0;
      lastDevQ <= '0;
      ceActive <= 1'b0;
      oeQ      <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.load) begin
        addrQ <= reqAddr[DEV_ADDR_W-1:0];
        devQ  <= newDev;
      end
      if (strobe.ceOn) ceActive <= 1'b1;
      if (strobe.oeOn) oeQ      <= 1'b1;
      if (strobe.capture) begin
        rspData  <= busData;
        lastDevQ <= devQ;
        ceActive <= 1'b0;
        oeQ      <= 1'b0;
      end
    end
  end

  // R9
  single_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~busCeN) <= 1);

  // R4
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busOeN |-> !(&busCeN));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(&busCeN) && !strobe.capture) |=> $stable(busAddr));

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6
  joint_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOeN) |-> (&busCeN));
endmodule

// File: rtl/romReadCtrl.sv
module romReadCtrl
  import romRdPkg::*;
#(
  parameter int NUM_DEV    = 4,
  parameter int DEV_ADDR_W = 16,
  parameter int DATA_W     = 16,
  parameter int ACC_CYC    = 6,
  parameter int OE_CYC     = 3,
  parameter int FLOAT_CYC  = 2,
  localparam int SEL_W     = $clog2(NUM_DEV),
  localparam int ADDR_W    = DEV_ADDR_W + SEL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ADDR_W-1:0]      reqAddr,
  output logic                   reqReady,
  output logic                   rspValid,
  output logic [DATA_W-1:0]      rspData,
  output logic [DEV_ADDR_W-1:0]  busAddr,
  output logic [NUM_DEV-1:0]     busCeN,
  output logic                   busOeN,
  input  logic [DATA_W-1:0]      busData
);
  rdStrobe_t strobe;
  logic      sameDev;

  romRdCtrl #(
    .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC), .FLOAT_CYC(FLOAT_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .sameDev(sameDev),
    .reqReady(reqReady), .strobe(strobe)
  );

  romRdDatapath #(
    .NUM_DEV(NUM_DEV), .DEV_ADDR_W(DEV_ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .busData(busData), .sameDev(sameDev), .busAddr(busAddr),
    .busCeN(busCeN), .busOeN(busOeN), .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: tb/romReadCtrl_test.sv
module romReadCtrl_test;
  localparam int NUM_DEV = 4, DEV_ADDR_W = 16, DATA_W = 16;
  localparam int ACC = 6, OEC = 3, FLT = 2;
  localparam int SEL_W = 2, ADDR_W = DEV_ADDR_W + SEL_W;
  localparam int OE_LEAD = ACC - OEC;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqReady, rspValid, busOeN;
  logic [DATA_W-1:0] rspData;
  logic [DATA_W-1:0] busData = 16'hDEAD;
  logic [DEV_ADDR_W-1:0] busAddr;
  logic [NUM_DEV-1:0] busCeN;

  romReadCtrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .busAddr(busAddr), .busCeN(busCeN), .busOeN(busOeN), .busData(busData)
  );

  int nCmp = 0, nBad = 0, cyc = 0;
  bit modelOn = 0, mBusy = 0, mRspNow = 0, haveData = 0, acceptSeen = 0;
  int mDev = 0, mAddr = 0, mCeFrom = 0, mCapAt = 0, mLastRel = -100, mLastDev = 0;
  logic [DATA_W-1:0] mData = '0;
  int ceCnt = 0, oeCnt = 0, ceDevPrev = -1;

  function automatic logic [DATA_W-1:0] romWord(int dev, int addr);
    return 16'(addr) ^ 16'(dev * 16'h2B59 + 16'h0101);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s edge %0d: got %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // reference model: per-request absolute edge numbers
  always @(posedge clk) if (modelOn) begin
    cyc++;
    mRspNow = 0;
    if (mBusy && cyc == mCapAt) begin
      mBusy = 0; mLastRel = cyc; mLastDev = mDev;
      mData = romWord(mDev, mAddr); mRspNow = 1; haveData = 1;
    end else if (!mBusy && reqValid) begin
      mDev  = int'(reqAddr[ADDR_W-1 -: SEL_W]);
      mAddr = int'(reqAddr[DEV_ADDR_W-1:0]);
      if (mDev == mLastDev || cyc >= mLastRel + FLT + 1) mCeFrom = cyc;
      else mCeFrom = mLastRel + FLT + 1;
      mCapAt = mCeFrom + ACC;
      mBusy = 1; acceptSeen = 1;
    end
  end

  always @(negedge clk) if (modelOn) begin
    logic [NUM_DEV-1:0] expCe;
    bit ceLow, oeLow;
    int nLow, lowDev;
    ceLow = mBusy && cyc >= mCeFrom;
    oeLow = mBusy && cyc >= mCeFrom + OE_LEAD;
    expCe = '1;
    if (ceLow) expCe[mDev] = 1'b0;
    check("R2 ready", 32'(reqReady), 32'(!mBusy));
    check("R3 R6 R7 R8 chip enables", 32'(busCeN), 32'(expCe));
    check("R4 R6 output enable", 32'(busOeN), 32'(!oeLow));
    if (ceLow) check("R3 address", 32'(busAddr), 32'(mAddr));
    check("R5 rspValid", 32'(rspValid), 32'(mRspNow));
    if (haveData) check("R5 rspData", 32'(rspData), 32'(mData));
    nLow = 0; lowDev = -1;
    for (int d = 0; d < NUM_DEV; d++) if (!busCeN[d]) begin nLow++; lowDev = d; end
    check("R9 enables low count", 32'(nLow <= 1), 32'd1);
    // memory model: poison until both access windows are met
    if (nLow == 1 && lowDev == ceDevPrev) ceCnt++;
    else if (nLow == 1) ceCnt = 1;
    else ceCnt = 0;
    ceDevPrev = (nLow == 1) ? lowDev : -1;
    oeCnt = busOeN ? 0 : oeCnt + 1;
    if (nLow == 1 && ceCnt >= ACC && oeCnt >= OEC) busData <= romWord(lowDev, int'(busAddr));
    else busData <= 16'hDEAD;
  end

  task automatic sendReq(input int dev, input int addr, input int idle);
    reqValid = 1'b0;
    repeat (idle) @(negedge clk);
    reqAddr = {SEL_W'(dev), DEV_ADDR_W'(addr)};
    reqValid = 1'b1;
    acceptSeen = 0;
    do @(negedge clk); while (!acceptSeen);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset enables", 32'(busCeN), 32'(4'hF));
    check("R1 reset oe", 32'(busOeN), 32'd1);
    check("R1 reset ready", 32'(reqReady), 32'd1);
    check("R1 reset rspValid", 32'(rspValid), 32'd0);
    rstN = 1'b1;
    modelOn = 1;
    sendReq(0, 16'h0000, 0);
    sendReq(0, 16'hFFFF, 0);
    sendReq(1, 16'h1234, 0);
    sendReq(1, 16'hA5A5, 3);
    sendReq(2, 16'h8001, 0);
    sendReq(3, 16'hFFFF, 5);
    sendReq(3, 16'h0000, 0);
    sendReq(0, 16'h00FF, 1);
    sendReq(2, 16'h7FFE, 2);
    sendReq(1, 16'h4242, 0);
    sendReq(1, 16'h0001, 0);
    sendReq(3, 16'hC3C3, 8);
    repeat (20) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end
endmodule